// File: doc/BRIEF.md
# Timestamped Event Lane Distributor

This block takes output-event write commands, each tagged with a channel, a coarse timestamp, an address and a data word. It steers every command into one of `LANES` lane queues. Inside any one lane the accepted timestamps must rise strictly. The block keeps the last timestamp written to each lane and a current-lane pointer, and decides in the same cycle where a command goes. The command is written to the current lane, written to the lane after it (round robin), held back, rejected as late, or dropped with a sequence-error pulse. The lane queues themselves sit outside the block. Each one shows a writable flag and takes a one-cycle write strobe together with a shared payload bus.

The command input is a valid/ready stream. The writer raises `cmd_valid` and holds the command stable until `cmd_ready` is high at a rising edge. `cmd_ready` goes low only when the chosen lane cannot take the write. While it is low, the command is tried again every cycle. The lane side has no back-pressure of its own: a lane may be strobed only while its writable flag is high. A two-bit status word goes back to the writer. Bit 0 is wait and bit 1 is underflow. A separate pulse reports sequence errors with the low 16 bits of the channel. Sequence errors never appear in the status word.

Top module: `evlane_distributor`

## Requirements
- R1: A command whose timestamp is strictly greater than the current lane's last timestamp, with that lane writable, is taken (`cmd_ready`=1) in the same cycle. Exactly that one bit of `lane_we` is high, and `lane_ts`/`lane_data`/`lane_chan`/`lane_addr` carry the command. That lane's stored last timestamp becomes the command's timestamp.
- R2: If the timestamp is not greater than the current lane's last timestamp but is greater than the next lane's (index current+1, wrapping to 0 after `LANES`-1), and the next lane is writable, the command is written to the next lane. The next lane then becomes the current lane.
- R3: If the timestamp is greater than neither lane's last timestamp, the command is taken and dropped with no lane strobe. In the following cycle `seq_err` is high for exactly one cycle and `seq_err_chan` holds bits 15:0 of `cmd_chan`.
- R4: A sequence error leaves the current lane and every stored timestamp unchanged, so later commands are handled normally.
- R5: A run of strictly increasing timestamps, with all lanes writable, never causes a sequence error and stays in lane 0 after reset.
- R6: If the current lane is not writable but the timestamp fits the next lane and the next lane is writable, the command goes to the next lane.
- R7: If the timestamp fits some lane (current first, then next) but no fitting lane is writable, `cmd_ready` is 0, `wr_status[0]` (wait) is 1, no strobe is raised, and the command is retried each cycle.
- R8: A command with timestamp below `now_coarse`+`MARGIN` (default 16) is an underflow. It is taken and dropped with no strobe, and `wr_status[1]` is 1 in the following cycle. A timestamp equal to `now_coarse`+`MARGIN` is not late. Underflow is checked before any lane test.
- R9: `wr_status[1]` is updated on every accepted command: it is cleared when an accepted command is not late, and holds its value while no command is accepted.
- R10: After reset all stored timestamps are 0, the current lane is 0, and `lane_we`, `wr_status`, `seq_err` are 0.
- R11: The result is deterministic from reset, and adding the same offset to every timestamp of a sequence gives the same set of sequence errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| now_coarse | input | TS_W | Present coarse time |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken this cycle when valid |
| cmd_chan | input | CHAN_W | Command channel |
| cmd_ts | input | TS_W | Command coarse timestamp |
| cmd_addr | input | ADDR_W | Command address |
| cmd_data | input | DATA_W | Command data |
| wr_status | output | 2 | Bit 0 wait, bit 1 underflow |
| lane_writable | input | LANES | Per-lane queue can accept a write |
| lane_we | output | LANES | Per-lane write strobe |
| lane_ts | output | TS_W | Payload timestamp to lanes |
| lane_chan | output | CHAN_W | Payload channel to lanes |
| lane_addr | output | ADDR_W | Payload address to lanes |
| lane_data | output | DATA_W | Payload data to lanes |
| seq_err | output | 1 | One-cycle sequence-error pulse |
| seq_err_chan | output | SEQCH_W | Low channel bits of the dropped command |

## Verification
The routing decision, `cmd_ready`, the wait bit and the lane strobe with its payload are all combinational on the cycle the command is presented. The bench drives each command just after a falling edge and samples these one time unit later, before the rising edge. The underflow bit and the sequence-error pulse are registered on the accepting edge, so they are sampled one time unit after that rising edge and compared with what the command just accepted should produce. A stalled command is sampled again on its retry cycle, which also shows that the underflow bit held through the stall.

// File: rtl/evlane_pkg.sv
package evlane_pkg;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_WRITE_CUR,
    EV_WRITE_NXT,
    EV_STALL,
    EV_LATE,
    EV_DROP
  } ev_outcome_e;

  localparam int STAT_WAIT_BIT  = 0;
  localparam int STAT_UNDER_BIT = 1;

endpackage

// File: rtl/lane_ts_bank.sv
module lane_ts_bank #(
  parameter int LANES  = 4,
  parameter int TS_W   = 32,
  parameter int LIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LIDX_W-1:0] wr_lane,
  input  logic [TS_W-1:0]   wr_ts,
  output logic [LIDX_W-1:0] cur_lane,
  output logic [LIDX_W-1:0] nxt_lane,
  output logic [TS_W-1:0]   last_cur,
  output logic [TS_W-1:0]   last_nxt
);

  logic [TS_W-1:0]   last_q [LANES];
  logic [LIDX_W-1:0] cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else if (wr_en) cur_q <= wr_lane;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q[g] <= '0;
      else if (wr_en && wr_lane == LIDX_W'(g)) last_q[g] <= wr_ts;
    end

    // R1: a lane's stored timestamp only ever rises
    assert_lane_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_lane == LIDX_W'(g)) |=> (last_q[g] > $past(last_q[g])));
  end

  always_comb begin
    if (cur_q == LIDX_W'(LANES - 1)) nxt_lane = '0;
    else nxt_lane = cur_q + 1'b1;
  end

  assign cur_lane = cur_q;
  assign last_cur = last_q[cur_q];
  assign last_nxt = last_q[nxt_lane];

endmodule

// File: rtl/lane_picker.sv
module lane_picker
  import evlane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int TS_W   = 32,
  parameter int LIDX_W = 2,
  parameter int MARGIN = 16
) (
  input  logic              valid,
  input  logic [TS_W-1:0]   ts,
  input  logic [TS_W-1:0]   now,
  input  logic [TS_W-1:0]   last_cur,
  input  logic [TS_W-1:0]   last_nxt,
  input  logic [LIDX_W-1:0] cur_lane,
  input  logic [LIDX_W-1:0] nxt_lane,
  input  logic [LANES-1:0]  writable,
  output logic              ready,
  output logic              wr_en,
  output logic [LIDX_W-1:0] wr_lane,
  output logic              late,
  output logic              drop
);

  logic [TS_W:0] min_ts;
  logic          too_late;
  logic          fits_cur;
  logic          fits_nxt;
  logic          cur_free;
  logic          nxt_free;
  ev_outcome_e   outcome;

  assign min_ts   = {1'b0, now} + (TS_W + 1)'(MARGIN);
  assign too_late = {1'b0, ts} < min_ts;
  assign fits_cur = ts > last_cur;
  assign fits_nxt = ts > last_nxt;
  assign cur_free = writable[cur_lane];
  assign nxt_free = writable[nxt_lane];

  always_comb begin
    if (!valid)                      outcome = EV_IDLE;
    else if (too_late)               outcome = EV_LATE;
    else if (fits_cur && cur_free)   outcome = EV_WRITE_CUR;
    else if (fits_nxt && nxt_free)   outcome = EV_WRITE_NXT;
    else if (fits_cur || fits_nxt)   outcome = EV_STALL;
    else                             outcome = EV_DROP;
  end

  always_comb begin
    ready   = (outcome != EV_STALL);
    wr_en   = (outcome == EV_WRITE_CUR) || (outcome == EV_WRITE_NXT);
    wr_lane = (outcome == EV_WRITE_NXT) ? nxt_lane : cur_lane;
    late    = (outcome == EV_LATE);
    drop    = (outcome == EV_DROP);
  end

endmodule

// File: rtl/dist_status.sv
module dist_status #(
  parameter int SEQCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               late,
  input  logic               drop,
  input  logic [SEQCH_W-1:0] chan_lo,
  output logic               under_q,
  output logic               seq_q,
  output logic [SEQCH_W-1:0] seq_chan_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      under_q    <= 1'b0;
      seq_q      <= 1'b0;
      seq_chan_q <= '0;
    end else begin
      seq_q <= take && drop;
      if (take) under_q <= late;
      if (take && drop) seq_chan_q <= chan_lo;
    end
  end

  // R9: without an accepted command the underflow flag holds
  assert_under_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(under_q));

endmodule

// File: rtl/evlane_distributor.sv
module evlane_distributor
  import evlane_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int TS_W    = 32,
  parameter int CHAN_W  = 24,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int MARGIN  = 16,
  parameter int SEQCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TS_W-1:0]    now_coarse,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [CHAN_W-1:0]  cmd_chan,
  input  logic [TS_W-1:0]    cmd_ts,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_data,
  output logic [1:0]         wr_status,
  input  logic [LANES-1:0]   lane_writable,
  output logic [LANES-1:0]   lane_we,
  output logic [TS_W-1:0]    lane_ts,
  output logic [CHAN_W-1:0]  lane_chan,
  output logic [ADDR_W-1:0]  lane_addr,
  output logic [DATA_W-1:0]  lane_data,
  output logic               seq_err,
  output logic [SEQCH_W-1:0] seq_err_chan
);

  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LIDX_W-1:0] cur_lane, nxt_lane, pk_lane;
  logic [TS_W-1:0]   last_cur, last_nxt;
  logic              pk_ready, pk_wr, pk_late, pk_drop;
  logic              take;
  logic              under_q;

  lane_ts_bank #(.LANES(LANES), .TS_W(TS_W), .LIDX_W(LIDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (pk_wr),
    .wr_lane  (pk_lane),
    .wr_ts    (cmd_ts),
    .cur_lane (cur_lane),
    .nxt_lane (nxt_lane),
    .last_cur (last_cur),
    .last_nxt (last_nxt)
  );

  lane_picker #(.LANES(LANES), .TS_W(TS_W), .LIDX_W(LIDX_W), .MARGIN(MARGIN)) u_pick (
    .valid    (cmd_valid),
    .ts       (cmd_ts),
    .now      (now_coarse),
    .last_cur (last_cur),
    .last_nxt (last_nxt),
    .cur_lane (cur_lane),
    .nxt_lane (nxt_lane),
    .writable (lane_writable),
    .ready    (pk_ready),
    .wr_en    (pk_wr),
    .wr_lane  (pk_lane),
    .late     (pk_late),
    .drop     (pk_drop)
  );

  assign take = cmd_valid && pk_ready;

  dist_status #(.SEQCH_W(SEQCH_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .late       (pk_late),
    .drop       (pk_drop),
    .chan_lo    (cmd_chan[SEQCH_W-1:0]),
    .under_q    (under_q),
    .seq_q      (seq_err),
    .seq_chan_q (seq_err_chan)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_we
    assign lane_we[g] = pk_wr && (pk_lane == LIDX_W'(g));
  end

  assign cmd_ready = pk_ready;
  assign lane_ts   = cmd_ts;
  assign lane_chan = cmd_chan;
  assign lane_addr = cmd_addr;
  assign lane_data = cmd_data;

  always_comb begin
    wr_status                 = '0;
    wr_status[STAT_WAIT_BIT]  = cmd_valid && !pk_ready;
    wr_status[STAT_UNDER_BIT] = under_q;
  end

  // R1: at most one lane strobed per cycle
  assert_one_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_we));

  // R6: a strobe never lands on a lane that cannot take it
  assert_we_writable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we & ~lane_writable) == '0);

  // R7: a waiting command raises no strobe
  assert_wait_no_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status[STAT_WAIT_BIT] |-> (lane_we == '0));

  // R3: a sequence-error pulse follows a cycle with no lane write
  assert_seq_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> ($past(lane_we) == '0));

  // R8: a late command is never written to a lane
  assert_late_no_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && ({1'b0, cmd_ts} < ({1'b0, now_coarse} + (TS_W + 1)'(MARGIN))))
      |-> (lane_we == '0));

  // R9: an accepted write clears the underflow flag
  assert_under_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (lane_we != '0)) |=> !wr_status[STAT_UNDER_BIT]);

endmodule

// File: tb/evlane_distributor_bench.sv
`timescale 1ns/1ps
module evlane_distributor_bench;

  localparam real HALF = 2.5;
  localparam int  NV   = 15;

  // vector table: timestamp, now, writable mask, expected ready, strobe mask,
  // sequence-error pulse, underflow bit, requirement number
  localparam int V_TS  [NV] = '{20, 30, 25, 40, 35, 35, 30, 36, 37, 10, 38, 116, 115, 200, 200};
  localparam int V_NOW [NV] = '{ 0,  0,  0,  0,  0,  0,  0,  0,  0,  0,  0, 100, 100, 100, 100};
  localparam int V_WR  [NV] = '{15, 15, 15, 15, 15, 15, 15, 15,  7, 15, 15,  15,  15,   0,   2};
  localparam int V_RDY [NV] = '{ 1,  1,  1,  1,  1,  1,  1,  1,  1,  1,  1,   1,   1,   0,   1};
  localparam int V_WE  [NV] = '{ 1,  1,  2,  2,  4,  8,  0,  8,  1,  0,  1,   1,   0,   0,   2};
  localparam int V_SEQ [NV] = '{ 0,  0,  0,  0,  0,  0,  1,  0,  0,  0,  0,   0,   0,   0,   0};
  localparam int V_UF  [NV] = '{ 0,  0,  0,  0,  0,  0,  0,  0,  0,  1,  0,   0,   1,   1,   0};
  // R1 R1 R2 R1 R2 R2 R3 R4 R6 R8 R9 R8 R8 R7 R7
  localparam int V_REQ [NV] = '{ 1,  1,  2,  1,  2,  2,  3,  4,  6,  8,  9,   8,   8,   7,   7};

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] now_coarse = 0;
  logic        cmd_valid = 0;
  logic        cmd_ready;
  logic [23:0] cmd_chan = 24'h5AC3E1;
  logic [31:0] cmd_ts = 0;
  logic [15:0] cmd_addr = 16'h0042;
  logic [31:0] cmd_data = 0;
  logic [1:0]  wr_status;
  logic [3:0]  lane_writable = 4'hF;
  logic [3:0]  lane_we;
  logic [31:0] lane_ts;
  logic [23:0] lane_chan;
  logic [15:0] lane_addr;
  logic [31:0] lane_data;
  logic        seq_err;
  logic [15:0] seq_err_chan;

  int total = 0;
  int bad   = 0;

  always #(HALF) clk = ~clk;

  evlane_distributor u_evlane_distributor (
    .clk(clk), .rst_n(rst_n), .now_coarse(now_coarse),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_chan(cmd_chan),
    .cmd_ts(cmd_ts), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .wr_status(wr_status), .lane_writable(lane_writable), .lane_we(lane_we),
    .lane_ts(lane_ts), .lane_chan(lane_chan), .lane_addr(lane_addr),
    .lane_data(lane_data), .seq_err(seq_err), .seq_err_chan(seq_err_chan)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cmd_valid = 0; now_coarse = 0; lane_writable = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // drive one command; sample comb outputs before the edge, registered ones after
  task automatic send(input int ts, input int now, input int wr,
                      output logic rdy, output logic [3:0] we, output logic wt,
                      output logic [31:0] dat, output logic se, output logic uf);
    @(negedge clk);
    cmd_valid = 1; cmd_ts = ts; now_coarse = now; lane_writable = wr[3:0];
    cmd_data = ts ^ 32'h5A5A0000;
    #1;
    rdy = cmd_ready; we = lane_we; wt = wr_status[0]; dat = lane_data;
    @(posedge clk);
    #1;
    se = seq_err; uf = wr_status[1];
  endtask

  initial begin
    #(HALF * 2 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic rdy, wt, se, uf;
    logic [3:0] we;
    logic [31:0] dat;
    int errs_a, errs_b;

    // R10: state right after reset
    do_reset();
    #1;
    chk("R10 lane_we", lane_we, 0);
    chk("R10 status", wr_status, 0);
    chk("R10 seq_err", seq_err, 0);
    chk("R10 ready idle", cmd_ready, 1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d v%0d", V_REQ[i], i);
      send(V_TS[i], V_NOW[i], V_WR[i], rdy, we, wt, dat, se, uf);
      chk({tag, " ready"}, rdy, V_RDY[i]);
      chk({tag, " wait"}, wt, !V_RDY[i]);
      chk({tag, " strobe"}, we, V_WE[i]);
      if (V_WE[i] != 0) chk({tag, " data"}, dat, V_TS[i] ^ 32'h5A5A0000);
      chk({tag, " seq"}, se, V_SEQ[i]);
      if (V_SEQ[i] != 0) chk({tag, " seq chan"}, seq_err_chan, 16'hC3E1);
      chk({tag, " underflow"}, uf, V_UF[i]);
    end
    @(negedge clk); cmd_valid = 0;
    @(posedge clk); #1;
    chk("R3 pulse one cycle", seq_err, 0);

    // R5: strictly increasing run stays in lane 0 with no error
    do_reset();
    for (int k = 0; k < 40; k++) begin
      send(20 + 3 * k, 0, 15, rdy, we, wt, dat, se, uf);
      chk("R5 strobe lane0", we, 1);
      chk("R5 no seq", se, 0);
    end

    // R11: same rewind pattern, with and without an offset
    errs_a = 0; errs_b = 0;
    do_reset();
    foreach (V_TS[j]) if (j < 6) begin
      send(int'(j < 5 ? 150 - 10 * j : 160), 0, 15, rdy, we, wt, dat, se, uf);
      if (se) errs_a++;
    end
    do_reset();
    foreach (V_TS[j]) if (j < 6) begin
      send(int'(j < 5 ? 1150 - 10 * j : 1160), 0, 15, rdy, we, wt, dat, se, uf);
      if (se) errs_b++;
    end
    chk("R11 errors base", errs_a, 1);
    chk("R11 errors offset", errs_b, errs_a);

    @(negedge clk); cmd_valid = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule